// File: doc/BRIEF.md
# LPC Peripheral Target Cycle Engine

This block is the target side of a Low Pin Count bus. It runs on the bus clock and watches the frame strobe and the four-bit multiplexed address/data lines. It accepts four kinds of single-byte transfer: I/O read, I/O write, DMA read and DMA write. It collects the address, or the DMA channel, and any data the host supplies. It then answers with turnaround and SYNC nibbles and either returns or accepts one data byte. Every other cycle type is left alone, and the target never drives the bus for it.

Behind the engine sits a plain 8-bit register port. The read or write strobe stays high for the whole SYNC phase. The engine inserts one wait nibble for each clock in which the register side holds `reg_ready` low. An I/O cycle always waits with the long-wait code, a DMA cycle always waits with the short-wait code, and the code stays the same for the whole cycle. The engine also passes an internal DMA request out to the bus request pin through a short register chain.

Top module: `lpc_target`

## Requirements
- R1: A cycle starts on a clock where `lframe_n` is low and `lad_i` is 0000. The next nibble is the cycle type: 0000 is an I/O read, 0010 an I/O write, 1000 a DMA read and 1010 a DMA write.
- R2: Any other cycle-type nibble is ignored, and so is a DMA size nibble other than 0000. For such a cycle `lad_oe` stays 0 and neither strobe rises until the next start.
- R3: An I/O cycle carries four address nibbles, most significant first, and they appear on `reg_addr`. A DMA cycle carries one channel nibble and then a size nibble. The channel appears on `reg_addr[3:0]` with the upper bits at zero.
- R4: When the host supplies data, it sends two nibbles, low nibble first, right after the address or size nibble. They appear on `reg_wdata`, and `reg_wr` is high throughout SYNC.
- R5: After the host's two turnaround clocks the target drives SYNC at once. When the target supplies data, `reg_rd` is high throughout SYNC, and the byte sampled from `reg_rdata` is driven low nibble first in the two clocks right after the ready code.
- R6: While `reg_ready` is low during SYNC, the target drives 0110 for an I/O cycle and 0101 for a DMA cycle. The code never changes within a cycle.
- R7: The target drives 0000 in the first SYNC clock in which `reg_ready` is high, so the number of wait nibbles equals the number of clocks before ready. The strobe drops on the next clock.
- R8: After its last nibble the target drives 1111 for one clock, then releases LAD and returns to idle.
- R9: `lframe_n` low in the middle of a cycle aborts it. LAD is released on the next clock. If LAD is 0000 on that clock, a new cycle starts.
- R10: While `rst_n` is low, LAD is released, `ldrq_n` is high, the strobes are low and `lframe_n` is ignored.
- R11: `ldrq_n` is the inverse of `dma_req`, delayed by REQ_STAGES clocks (2 by default).
- R12: In a DMA cycle the host supplies data for type 1000 and the target supplies it for type 1010. `reg_dma` is high for both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus reset, active low |
| lframe_n | input | 1 | Frame strobe, active low |
| lad_i | input | 4 | LAD value sampled from the bus |
| lad_o | output | 4 | LAD value driven by the target |
| lad_oe | output | 1 | LAD output enable |
| ldrq_n | output | 1 | DMA request pin, active low |
| dma_req | input | 1 | Internal DMA request |
| reg_addr | output | 16 | I/O address or DMA channel |
| reg_wdata | output | 8 | Byte supplied by the host |
| reg_rd | output | 1 | Read strobe, held until ready |
| reg_wr | output | 1 | Write strobe, held until ready |
| reg_dma | output | 1 | Current cycle is a DMA cycle |
| reg_rdata | input | 8 | Byte returned by the register side |
| reg_ready | input | 1 | Register side done |

## Verification
Transfers of all four classes run with ready delays from 0 to 8 clocks and random addresses, channels and bytes. Counting the wait nibbles separates an off-by-one in the ready path from a wrong wait code, and mixing classes shows whether the code follows the cycle class. Directed cases cover reserved cycle types, a bad DMA size, and aborts during the address and during SYNC, with and without a restart nibble. Together they show whether the bus is ever driven outside a valid cycle. Reset is tested with the frame strobe held active.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_CTYPE, S_ADDR, S_DCHAN, S_DSIZE,
      S_HDATA, S_HTAR, S_SYNC, S_TDATA, S_TTAR
   } lpc_st_e;

   localparam logic [3:0] NIB_START    = 4'b0000;
   localparam logic [3:0] NIB_READY    = 4'b0000;
   localparam logic [3:0] NIB_TAR      = 4'b1111;
   localparam logic [3:0] CT_IO_RD     = 4'b0000;
   localparam logic [3:0] CT_IO_WR     = 4'b0010;
   localparam logic [3:0] CT_DMA_RD    = 4'b1000;
   localparam logic [3:0] CT_DMA_WR    = 4'b1010;
   localparam logic [3:0] DMA_SIZE_ONE = 4'b0000;
endpackage

// File: rtl/lpc_tgt_fsm.sv
module lpc_tgt_fsm
   import lpc_tgt_pkg::*;
#(
   parameter int ADDR_NIBBLES = 4,
   parameter int CNT_W        = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lframe_n,
   input  logic [3:0]       lad_i,
   input  logic             reg_ready,
   output lpc_st_e          st,
   output logic [CNT_W-1:0] cnt,
   output logic             is_dma,
   output logic             host_drv
);
   localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_NIBBLES - 1);
   localparam logic [CNT_W-1:0] LAST_PAIR = CNT_W'(1);

   lpc_st_e          st_n;
   logic [CNT_W-1:0] cnt_n;
   logic             dma_n, hd_n;

   always_comb begin
      st_n  = st;
      cnt_n = '0;
      dma_n = is_dma;
      hd_n  = host_drv;
      if (!lframe_n) begin
         st_n = (lad_i == NIB_START) ? S_CTYPE : S_IDLE;
      end else begin
         case (st)
            S_IDLE: st_n = S_IDLE;
            S_CTYPE: begin
               case (lad_i)
                  CT_IO_RD:  begin st_n = S_ADDR;  dma_n = 1'b0; hd_n = 1'b0; end
                  CT_IO_WR:  begin st_n = S_ADDR;  dma_n = 1'b0; hd_n = 1'b1; end
                  CT_DMA_RD: begin st_n = S_DCHAN; dma_n = 1'b1; hd_n = 1'b1; end
                  CT_DMA_WR: begin st_n = S_DCHAN; dma_n = 1'b1; hd_n = 1'b0; end
                  default:   st_n = S_IDLE;
               endcase
            end
            S_ADDR: begin
               if (cnt == LAST_ADDR) st_n = host_drv ? S_HDATA : S_HTAR;
               else                  cnt_n = cnt + 1'b1;
            end
            S_DCHAN: st_n = S_DSIZE;
            S_DSIZE: begin
               if (lad_i == DMA_SIZE_ONE) st_n = host_drv ? S_HDATA : S_HTAR;
               else                       st_n = S_IDLE;
            end
            S_HDATA: begin
               if (cnt == LAST_PAIR) st_n = S_HTAR;
               else                  cnt_n = cnt + 1'b1;
            end
            S_HTAR: begin
               if (cnt == LAST_PAIR) st_n = S_SYNC;
               else                  cnt_n = cnt + 1'b1;
            end
            S_SYNC: begin
               if (reg_ready) st_n = host_drv ? S_TTAR : S_TDATA;
            end
            S_TDATA: begin
               if (cnt == LAST_PAIR) st_n = S_TTAR;
               else                  cnt_n = cnt + 1'b1;
            end
            S_TTAR: begin
               if (cnt == LAST_PAIR) st_n = S_IDLE;
               else                  cnt_n = cnt + 1'b1;
            end
            default: st_n = S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cnt      <= '0;
         is_dma   <= 1'b0;
         host_drv <= 1'b0;
      end else begin
         st       <= st_n;
         cnt      <= cnt_n;
         is_dma   <= dma_n;
         host_drv <= hd_n;
      end
   end

   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!lframe_n && lad_i != NIB_START) |=> st == S_IDLE); // R9
   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (!lframe_n && lad_i == NIB_START) |=> st == S_CTYPE); // R9
endmodule

// File: rtl/lpc_tgt_datapath.sv
module lpc_tgt_datapath
   import lpc_tgt_pkg::*;
#(
   parameter int         ADDR_NIBBLES  = 4,
   parameter int         CNT_W         = 2,
   parameter logic [3:0] IO_WAIT_CODE  = 4'b0110,
   parameter logic [3:0] DMA_WAIT_CODE = 4'b0101,
   localparam int        ADDR_W        = 4 * ADDR_NIBBLES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lpc_st_e           st,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              is_dma,
   input  logic              host_drv,
   input  logic [3:0]        lad_i,
   input  logic              reg_ready,
   input  logic [7:0]        reg_rdata,
   output logic [ADDR_W-1:0] addr,
   output logic [7:0]        wdata,
   output logic [3:0]        lad_o,
   output logic              lad_oe
);
   logic [7:0] rdata_q;
   logic [3:0] wait_code;

   assign wait_code = is_dma ? DMA_WAIT_CODE : IO_WAIT_CODE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr    <= '0;
         wdata   <= '0;
         rdata_q <= '0;
      end else begin
         case (st)
            S_ADDR:  addr <= {addr[ADDR_W-5:0], lad_i};
            S_DCHAN: addr <= ADDR_W'(lad_i);
            S_HDATA: begin
               if (cnt[0]) wdata[7:4] <= lad_i;
               else        wdata[3:0] <= lad_i;
            end
            S_SYNC:  if (reg_ready && !host_drv) rdata_q <= reg_rdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      lad_o  = 4'b0000;
      lad_oe = 1'b0;
      case (st)
         S_SYNC: begin
            lad_oe = 1'b1;
            lad_o  = reg_ready ? NIB_READY : wait_code;
         end
         S_TDATA: begin
            lad_oe = 1'b1;
            lad_o  = cnt[0] ? rdata_q[7:4] : rdata_q[3:0];
         end
         S_TTAR: begin
            lad_oe = (cnt == '0);
            lad_o  = NIB_TAR;
         end
         default: ;
      endcase
   end

   AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_SYNC && $past(st) == S_SYNC && !reg_ready && !$past(reg_ready))
      |-> lad_o == $past(lad_o)); // R6
endmodule

// File: rtl/lpc_tgt_reqsync.sv
module lpc_tgt_reqsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic ldrq_n
);
   logic [STAGES-1:0] q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= req;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= {q[STAGES-2:0], req};
         end
      end
   endgenerate

   assign ldrq_n = ~q[STAGES-1];
endmodule

// File: rtl/lpc_target.sv
module lpc_target
   import lpc_tgt_pkg::*;
#(
   parameter int         ADDR_NIBBLES  = 4,
   parameter int         REQ_STAGES    = 2,
   parameter logic [3:0] IO_WAIT_CODE  = 4'b0110,
   parameter logic [3:0] DMA_WAIT_CODE = 4'b0101,
   localparam int        ADDR_W        = 4 * ADDR_NIBBLES,
   localparam int        CNT_W         = (ADDR_NIBBLES > 2) ? $clog2(ADDR_NIBBLES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lframe_n,
   input  logic [3:0]        lad_i,
   output logic [3:0]        lad_o,
   output logic              lad_oe,
   output logic              ldrq_n,
   input  logic              dma_req,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   output logic              reg_rd,
   output logic              reg_wr,
   output logic              reg_dma,
   input  logic [7:0]        reg_rdata,
   input  logic              reg_ready
);
   initial begin
      assert (ADDR_NIBBLES >= 2 && ADDR_NIBBLES <= 8)
         else $error("ADDR_NIBBLES out of range");
      assert (REQ_STAGES >= 1 && REQ_STAGES <= 3)
         else $error("REQ_STAGES out of range");
      assert (IO_WAIT_CODE != NIB_READY && DMA_WAIT_CODE != NIB_READY)
         else $error("wait code collides with ready code");
   end

   lpc_st_e          st;
   logic [CNT_W-1:0] cnt;
   logic             is_dma, host_drv;

   lpc_tgt_fsm #(.ADDR_NIBBLES(ADDR_NIBBLES), .CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_i(lad_i),
      .reg_ready(reg_ready), .st(st), .cnt(cnt), .is_dma(is_dma),
      .host_drv(host_drv)
   );

   lpc_tgt_datapath #(
      .ADDR_NIBBLES(ADDR_NIBBLES), .CNT_W(CNT_W),
      .IO_WAIT_CODE(IO_WAIT_CODE), .DMA_WAIT_CODE(DMA_WAIT_CODE)
   ) u_dp (
      .clk(clk), .rst_n(rst_n), .st(st), .cnt(cnt), .is_dma(is_dma),
      .host_drv(host_drv), .lad_i(lad_i), .reg_ready(reg_ready),
      .reg_rdata(reg_rdata), .addr(reg_addr), .wdata(reg_wdata),
      .lad_o(lad_o), .lad_oe(lad_oe)
   );

   lpc_tgt_reqsync #(.STAGES(REQ_STAGES)) u_req (
      .clk(clk), .rst_n(rst_n), .req(dma_req), .ldrq_n(ldrq_n)
   );

   assign reg_rd  = (st == S_SYNC) && !host_drv;
   assign reg_wr  = (st == S_SYNC) &&  host_drv;
   assign reg_dma = is_dma;

   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!lad_oe && ldrq_n && !reg_rd && !reg_wr); // R10
      end
   end

   AST_STROBE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_ready && (reg_rd || reg_wr) && lframe_n) |=> !(reg_rd || reg_wr)); // R7
   AST_TAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lad_oe) && $past(lframe_n)) |-> $past(lad_o) == NIB_TAR); // R8
endmodule

// File: tb/test_lpc_target.sv
module test_lpc_target;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lframe_n = 1'b1;
   logic [3:0]  lad_i = 4'hF;
   logic        dma_req = 1'b0;
   logic [7:0]  reg_rdata = 8'h00;
   logic        reg_ready = 1'b0;
   logic [3:0]  lad_o;
   logic        lad_oe, ldrq_n, reg_rd, reg_wr, reg_dma;
   logic [15:0] reg_addr;
   logic [7:0]  reg_wdata;

   int errs = 0;
   int checks = 0;
   int wait_n = 0;
   int scnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lpc_target i_lpc_target (
      .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_i(lad_i),
      .lad_o(lad_o), .lad_oe(lad_oe), .ldrq_n(ldrq_n), .dma_req(dma_req),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
      .reg_wr(reg_wr), .reg_dma(reg_dma), .reg_rdata(reg_rdata),
      .reg_ready(reg_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one bus clock: drive, let an edge pass, update the register-side model, settle
   task automatic tick(input logic lf, input logic [3:0] nib);
      lframe_n = lf;
      lad_i    = nib;
      @(posedge clk);
      @(negedge clk);
      if (reg_rd || reg_wr) begin
         reg_ready = (scnt >= wait_n);
         scnt++;
      end else begin
         reg_ready = 1'b0;
         scnt = 0;
      end
      #1;
   endtask

   function automatic logic [3:0] ctype(input bit dma, input bit hostdata);
      if (dma) return hostdata ? 4'h8 : 4'hA;   // R12
      return hostdata ? 4'h2 : 4'h0;            // R1
   endfunction

   function automatic logic [3:0] wait_code(input bit dma);
      return dma ? 4'b0101 : 4'b0110;
   endfunction

   task automatic xfer(input bit dma, input bit hostdata, input logic [15:0] addr,
                       input logic [3:0] chan, input int w, input logic [7:0] d);
      logic [15:0] exp_addr;
      int n;
      wait_n = w;
      reg_rdata = d;
      exp_addr = dma ? {12'h000, chan} : addr;
      tick(1'b0, 4'h0);
      tick(1'b1, ctype(dma, hostdata));
      if (dma) begin
         tick(1'b1, chan);
         tick(1'b1, 4'h0);
      end else begin
         for (int i = 3; i >= 0; i--) tick(1'b1, addr[4*i +: 4]);
      end
      if (hostdata) begin
         tick(1'b1, d[3:0]);
         tick(1'b1, d[7:4]);
      end
      tick(1'b1, 4'hF);
      tick(1'b1, 4'hF);
      // first SYNC clock (R5)
      chk(lad_oe, "R5 sync driven", lad_oe, 1);
      chk(reg_addr == exp_addr, "R3 address", reg_addr, exp_addr);
      chk(reg_dma == dma, "R12 dma flag", reg_dma, dma);
      if (hostdata) begin
         chk(reg_wr && !reg_rd, "R4 write strobe", {reg_wr, reg_rd}, 2'b10);
         chk(reg_wdata == d, "R4 write data", reg_wdata, d);
      end else begin
         chk(reg_rd && !reg_wr, "R5 read strobe", {reg_wr, reg_rd}, 2'b01);
      end
      n = 0;
      while (lad_oe && lad_o == wait_code(dma) && n < 12) begin
         n++;
         tick(1'b1, 4'hF);
      end
      chk(n == w, "R6 R7 wait count", n, w);
      chk(lad_oe && lad_o == 4'h0, "R7 ready code", lad_o, 0);
      tick(1'b1, 4'hF);
      chk(!reg_rd && !reg_wr, "R7 strobe drop", {reg_wr, reg_rd}, 0);
      if (!hostdata) begin
         chk(lad_oe && lad_o == d[3:0], "R5 data low", lad_o, d[3:0]);
         tick(1'b1, 4'hF);
         chk(lad_oe && lad_o == d[7:4], "R5 data high", lad_o, d[7:4]);
         tick(1'b1, 4'hF);
      end
      chk(lad_oe && lad_o == 4'hF, "R8 turnaround drive", lad_o, 4'hF);
      tick(1'b1, 4'hF);
      chk(!lad_oe, "R8 release", lad_oe, 0);
   endtask

   // frames that must stay silent (R2)
   task automatic silent_frame(input logic [3:0] ct, input bit dma_bad_size);
      bit drove;
      drove = 1'b0;
      tick(1'b0, 4'h0);
      tick(1'b1, ct);
      if (dma_bad_size) begin
         tick(1'b1, 4'h2);
         tick(1'b1, 4'h1);
      end
      for (int i = 0; i < 10; i++) begin
         tick(1'b1, 4'(i));
         if (lad_oe || reg_rd || reg_wr) drove = 1'b1;
      end
      chk(!drove, "R2 ignored cycle", drove, 0);
   endtask

   initial begin
      void'($urandom(32'd2718));
      // reset with a frame held active (R10)
      dma_req = 1'b1;
      tick(1'b0, 4'h0);
      tick(1'b0, 4'h0);
      chk(!lad_oe, "R10 lad released", lad_oe, 0);
      chk(ldrq_n, "R10 request high", ldrq_n, 1);
      chk(!reg_rd && !reg_wr, "R10 strobes low", {reg_wr, reg_rd}, 0);
      dma_req = 1'b0;
      rst_n = 1'b1;
      tick(1'b1, 4'hF);
      tick(1'b1, 4'hF);
      chk(!lad_oe && ldrq_n, "R10 idle after reset", {lad_oe, ldrq_n}, 1);

      // request pin latency (R11)
      dma_req = 1'b1;
      tick(1'b1, 4'hF);
      chk(ldrq_n, "R11 one clock", ldrq_n, 1);
      tick(1'b1, 4'hF);
      chk(!ldrq_n, "R11 two clocks", ldrq_n, 0);
      dma_req = 1'b0;
      tick(1'b1, 4'hF);
      tick(1'b1, 4'hF);
      chk(ldrq_n, "R11 release", ldrq_n, 1);

      // directed transfers (R1 R3 R4 R5 R6 R7 R8 R12)
      xfer(1'b0, 1'b0, 16'h12A5, 4'h0, 0, 8'h3C);
      xfer(1'b0, 1'b1, 16'hFE01, 4'h0, 8, 8'hA7);
      xfer(1'b1, 1'b1, 16'h0000, 4'h3, 1, 8'h5E);
      xfer(1'b1, 1'b0, 16'h0000, 4'hE, 8, 8'hC1);

      // ignored cycles (R2)
      silent_frame(4'h4, 1'b0);
      silent_frame(4'h1, 1'b0);
      silent_frame(4'hC, 1'b0);
      silent_frame(4'h8, 1'b1);

      // abort during address, no restart (R9)
      tick(1'b0, 4'h0);
      tick(1'b1, 4'h0);
      tick(1'b1, 4'h1);
      tick(1'b0, 4'h3);
      tick(1'b1, 4'h0);
      tick(1'b1, 4'h0);
      tick(1'b1, 4'hF);
      tick(1'b1, 4'hF);
      chk(!lad_oe && !reg_rd, "R9 abort address", {lad_oe, reg_rd}, 0);

      // abort during SYNC wait (R9)
      wait_n = 8;
      tick(1'b0, 4'h0);
      tick(1'b1, 4'h0);
      for (int i = 0; i < 4; i++) tick(1'b1, 4'h7);
      tick(1'b1, 4'hF);
      tick(1'b1, 4'hF);
      chk(lad_oe && lad_o == 4'b0110, "R6 io wait code", lad_o, 4'b0110);
      tick(1'b1, 4'hF);
      tick(1'b0, 4'h5);
      chk(!lad_oe && !reg_rd, "R9 abort sync", {lad_oe, reg_rd}, 0);
      tick(1'b1, 4'hF);

      // abort with restart (R9)
      tick(1'b0, 4'h0);
      tick(1'b1, 4'h2);
      tick(1'b1, 4'h9);
      xfer(1'b0, 1'b0, 16'h0BEE, 4'h0, 3, 8'h96);

      // random mix
      for (int k = 0; k < 40; k++) begin
         bit dma, hd;
         dma = 1'($urandom);
         hd  = 1'($urandom);
         xfer(dma, hd, 16'($urandom), 4'($urandom), int'($urandom % 9), 8'($urandom));
         repeat (int'($urandom % 3)) tick(1'b1, 4'hF);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule